// File: doc/BRIEF.md
# Serial Mode-Word Register Port

This block receives 16-bit control words over three slow lines: a data line, a shift clock and a latch strobe. All three are sampled in the system clock domain. Each word carries a 2-bit register select and a 9-bit payload. On the latch strobe, the payload goes into one of four fixed-layout mode registers.

Two of the registers hold per-channel attenuation values. A new value is staged first and only becomes active when a word arrives with its load bit set. That load updates both active channels in the same cycle. The other two registers hold the format fields and the system fields, and the block exports every field as its own output.

The right-channel attenuation output follows the left active value whenever the common-attenuation field is set.

Top module: `mode_word_port`

## Requirements
- R1: After synchronous reset, both attenuation outputs read 255 and every other output field reads 0.
- R2: A word is shifted in most-significant bit first, one bit per rising edge of the shift clock line. A rising edge of the latch line after exactly 16 such bits writes the word. Bits 10:9 select the register (0 left attenuation, 1 right attenuation, 2 format, 3 system). Bits 15:11 have no effect.
- R3: A latch edge that follows fewer than 16 or more than 16 shift edges writes nothing. The next word starts counting afresh.
- R4: A write to register 0 or 1 with bit 8 (load) at 0 stores bits 7:0 as that channel's staged value and leaves both attenuation outputs unchanged.
- R5: A write to register 0 or 1 with load at 1 stores the new value and moves both staged values (left and right) to the active attenuation in the same cycle.
- R6: While the common-attenuation field is 1, the right attenuation output equals the left active value. While it is 0, it shows the right active value.
- R7: Register 2 fields are: mute bit 0, de-emphasis bit 1, operation enable bit 2, word length bits 4:3, output mode bits 8:5.
- R8: Register 3 fields are: I2S-format select bit 0, word-clock polarity bit 1, common attenuation bit 2, system clock select bit 3 (1 = 256 x fs, 0 = 384 x fs), rate multiplier bits 5:4, rate group bits 7:6, zero-detect enable bit 8. Codes are exported as written.
- R9: A write to one register leaves the contents of the other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock line (asynchronous) |
| ser_dat_i | input | 1 | Serial data line (asynchronous) |
| ser_lat_i | input | 1 | Serial latch line (asynchronous) |
| att_l_o | output | 8 | Active left attenuation |
| att_r_o | output | 8 | Effective right attenuation |
| mute_o | output | 1 | Soft mute request |
| deemph_o | output | 1 | De-emphasis enable |
| op_en_o | output | 1 | Operation enable field |
| word_len_o | output | 2 | Input word length code |
| out_mode_o | output | 4 | Output mode code |
| i2s_sel_o | output | 1 | Data format select |
| lr_pol_o | output | 1 | Word clock polarity |
| att_common_o | output | 1 | Common attenuation enable |
| sysclk_256_o | output | 1 | System clock select, 1 = 256 x fs |
| rate_mult_o | output | 2 | Rate multiplier code |
| rate_group_o | output | 2 | Sample-rate group code |
| zero_det_en_o | output | 1 | Zero-detect enable |

## Verification
The hardest situation to reach is a pair of staged attenuation values that differ from the active ones. A single write with the load bit set must then make both of them active in one step. The stimulus first writes left and right values with load cleared and confirms that neither output moves. It then writes the right register with load set and checks that both outputs change, the left one to the value staged earlier. Miscounted words are produced by pulsing the latch after 15 and after 17 shift edges.

// File: rtl/mode_word_pkg.sv
package mode_word_pkg;
    localparam int WORD_W   = 16;
    localparam int ADDR_LSB = 9;
    localparam int ADDR_W   = 2;
    localparam int ATT_W    = 8;
    localparam int KEEP_W   = ADDR_LSB + ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ATT_L = 2'd0,
        SEL_ATT_R = 2'd1,
        SEL_FMT   = 2'd2,
        SEL_SYS   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       load;
        logic [7:0] value;
    } att_word_t;

    typedef struct packed {
        logic [3:0] out_mode;
        logic [1:0] word_len;
        logic       op_en;
        logic       deemph;
        logic       mute;
    } fmt_reg_t;

    typedef struct packed {
        logic       zero_det_en;
        logic [1:0] rate_group;
        logic [1:0] rate_mult;
        logic       sysclk_256;
        logic       att_common;
        logic       lr_pol;
        logic       i2s_sel;
    } sys_reg_t;

    function automatic reg_sel_e sel_of(input logic [KEEP_W-1:0] w);
        return reg_sel_e'(w[ADDR_LSB +: ADDR_W]);
    endfunction
endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] level_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-2:0], raw_i[g]};
        end
        assign level_o[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/word_shifter.sv
module word_shifter
    import mode_word_pkg::*;
#(
    parameter int FRAME_W = WORD_W,
    parameter int OUT_W   = KEEP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_lvl,
    input  logic             sdat_lvl,
    input  logic             slat_lvl,
    output logic             valid_o,
    output logic [OUT_W-1:0] word_o
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_W + 1);

    logic             sclk_q, slat_q;
    logic             shift_en, latch_en;
    logic [CNT_W-1:0] cnt;
    logic [OUT_W-1:0] sh;

    assign shift_en = sclk_lvl & ~sclk_q;
    assign latch_en = slat_lvl & ~slat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            slat_q  <= 1'b0;
            cnt     <= '0;
            sh      <= '0;
            valid_o <= 1'b0;
        end else begin
            sclk_q  <= sclk_lvl;
            slat_q  <= slat_lvl;
            valid_o <= 1'b0;
            if (latch_en) begin
                valid_o <= (cnt == FULL);
                cnt     <= '0;
            end else if (shift_en) begin
                sh <= {sh[OUT_W-2:0], sdat_lvl};
                if (cnt != OVER) cnt <= cnt + 1'b1;
            end
        end
    end

    assign word_o = sh;

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        cnt <= OVER) else $error("bit counter past saturation"); // R3
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o) else $error("write strobe longer than one cycle"); // R2
    AST_SHIFT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> cnt == '0) else $error("counter not restarted after latch"); // R3
endmodule

// File: rtl/mode_regfile.sv
module mode_regfile
    import mode_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [KEEP_W-1:0] wr_word,
    output logic [ATT_W-1:0]  act_l_o,
    output logic [ATT_W-1:0]  act_r_o,
    output fmt_reg_t          fmt_o,
    output sys_reg_t          sys_o
);
    reg_sel_e         sel;
    att_word_t        aw;
    logic [ATT_W-1:0] stg_l, stg_r;

    assign sel = sel_of(wr_word);
    assign aw  = att_word_t'(wr_word[ADDR_LSB-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_l   <= '1;
            stg_r   <= '1;
            act_l_o <= '1;
            act_r_o <= '1;
            fmt_o   <= '0;
            sys_o   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_ATT_L: begin
                    stg_l <= aw.value;
                    if (aw.load) begin
                        act_l_o <= aw.value;
                        act_r_o <= stg_r;
                    end
                end
                SEL_ATT_R: begin
                    stg_r <= aw.value;
                    if (aw.load) begin
                        act_l_o <= stg_l;
                        act_r_o <= aw.value;
                    end
                end
                SEL_FMT: fmt_o <= fmt_reg_t'(wr_word[ADDR_LSB-1:0]);
                default: sys_o <= sys_reg_t'(wr_word[ADDR_LSB-1:0]);
            endcase
        end
    end

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_en && (sel == SEL_ATT_L || sel == SEL_ATT_R) && !aw.load
        |=> $stable(act_l_o) && $stable(act_r_o)) else $error("staged write moved active value"); // R4
    AST_LOAD_PAIR: assert property (@(posedge clk) disable iff (rst)
        wr_en && (sel == SEL_ATT_L || sel == SEL_ATT_R) && aw.load
        |=> act_l_o == stg_l && act_r_o == stg_r) else $error("load did not transfer both channels"); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(fmt_o) && $stable(sys_o) && $stable(stg_l) && $stable(stg_r))
        else $error("register changed without a write"); // R2
    AST_SYS_ONLY: assert property (@(posedge clk) disable iff (rst)
        wr_en && sel == SEL_SYS |=> $stable(fmt_o) && $stable(act_l_o) && $stable(act_r_o))
        else $error("system write disturbed another register"); // R9
endmodule

// File: rtl/mode_word_port.sv
module mode_word_port
    import mode_word_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_lat_i,
    output logic [ATT_W-1:0] att_l_o,
    output logic [ATT_W-1:0] att_r_o,
    output logic             mute_o,
    output logic             deemph_o,
    output logic             op_en_o,
    output logic [1:0]       word_len_o,
    output logic [3:0]       out_mode_o,
    output logic             i2s_sel_o,
    output logic             lr_pol_o,
    output logic             att_common_o,
    output logic             sysclk_256_o,
    output logic [1:0]       rate_mult_o,
    output logic [1:0]       rate_group_o,
    output logic             zero_det_en_o
);
    logic [2:0]        lvl;
    logic              wr_en;
    logic [KEEP_W-1:0] wr_word;
    logic [ATT_W-1:0]  act_l, act_r;
    fmt_reg_t          fmt;
    sys_reg_t          sys;

    line_sync #(.LINES(3), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst),
        .raw_i({ser_lat_i, ser_dat_i, ser_clk_i}),
        .level_o(lvl)
    );

    word_shifter #(.FRAME_W(WORD_W), .OUT_W(KEEP_W)) u_shift (
        .clk(clk), .rst(rst),
        .sclk_lvl(lvl[0]), .sdat_lvl(lvl[1]), .slat_lvl(lvl[2]),
        .valid_o(wr_en), .word_o(wr_word)
    );

    mode_regfile u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_word(wr_word),
        .act_l_o(act_l), .act_r_o(act_r),
        .fmt_o(fmt), .sys_o(sys)
    );

    assign att_l_o       = act_l;
    assign att_r_o       = sys.att_common ? act_l : act_r;
    assign mute_o        = fmt.mute;
    assign deemph_o      = fmt.deemph;
    assign op_en_o       = fmt.op_en;
    assign word_len_o    = fmt.word_len;
    assign out_mode_o    = fmt.out_mode;
    assign i2s_sel_o     = sys.i2s_sel;
    assign lr_pol_o      = sys.lr_pol;
    assign att_common_o  = sys.att_common;
    assign sysclk_256_o  = sys.sysclk_256;
    assign rate_mult_o   = sys.rate_mult;
    assign rate_group_o  = sys.rate_group;
    assign zero_det_en_o = sys.zero_det_en;

    AST_RIGHT_STEADY: assert property (@(posedge clk) disable iff (rst)
        !wr_en && !$past(wr_en) |=> $stable(att_r_o)) else $error("right attenuation moved with no write"); // R6
endmodule

// File: tb/tb_mode_word_port.sv
module tb_mode_word_port;
    logic clk = 0, rst = 1;
    logic sck = 0, sdt = 0, slt = 0;
    logic [7:0] att_l, att_r;
    logic mute, deemph, op_en, i2s, lrp, common, sys256, zde;
    logic [1:0] wl, rmul, rgrp;
    logic [3:0] omode;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    mode_word_port dut (
        .clk(clk), .rst(rst), .ser_clk_i(sck), .ser_dat_i(sdt), .ser_lat_i(slt),
        .att_l_o(att_l), .att_r_o(att_r), .mute_o(mute), .deemph_o(deemph),
        .op_en_o(op_en), .word_len_o(wl), .out_mode_o(omode), .i2s_sel_o(i2s),
        .lr_pol_o(lrp), .att_common_o(common), .sysclk_256_o(sys256),
        .rate_mult_o(rmul), .rate_group_o(rgrp), .zero_det_en_o(zde)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] mk(input logic [4:0] rsv, input logic [1:0] a, input logic [8:0] d);
        return {rsv, a, d};
    endfunction

    // send the low nbits of w, most significant first, then pulse latch
    task automatic send(input logic [16:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdt = w[i]; idle(3);
            sck = 1;    idle(3);
            sck = 0;    idle(3);
        end
        slt = 1; idle(3);
        slt = 0; idle(8);
    endtask

    task automatic t_reset;
        chk("R1 att_l", att_l, 255);
        chk("R1 att_r", att_r, 255);
        chk("R1 fmt", {omode, wl, op_en, deemph, mute}, 0);
        chk("R1 sys", {zde, rgrp, rmul, sys256, common, lrp, i2s}, 0);
    endtask

    task automatic t_fmt;
        send({1'b0, mk(5'b10101, 2'd2, 9'b1010_10_1_0_1)}, 16);
        chk("R7 mute", mute, 1);
        chk("R7 deemph", deemph, 0);
        chk("R7 op_en", op_en, 1);
        chk("R7 word_len", wl, 2);
        chk("R7 out_mode", omode, 10);
        chk("R2 reserved bits ignored, att_l", att_l, 255);
    endtask

    task automatic t_sys;
        send({1'b0, mk(5'b0, 2'd3, 9'b1_01_10_1_0_1_0)}, 16);
        chk("R8 i2s", i2s, 0);
        chk("R8 lr_pol", lrp, 1);
        chk("R8 common", common, 0);
        chk("R8 sysclk_256", sys256, 1);
        chk("R8 rate_mult", rmul, 2);
        chk("R8 rate_group", rgrp, 1);
        chk("R8 zero_det", zde, 1);
        chk("R9 fmt kept", {omode, wl, op_en, deemph, mute}, 9'b1010_10_1_0_1);
    endtask

    task automatic t_stage;
        send({1'b0, mk(5'b0, 2'd0, {1'b0, 8'h40})}, 16);
        chk("R4 left stage, att_l", att_l, 255);
        chk("R4 left stage, att_r", att_r, 255);
        send({1'b0, mk(5'b0, 2'd1, {1'b0, 8'h22})}, 16);
        chk("R4 right stage, att_r", att_r, 255);
        send({1'b0, mk(5'b0, 2'd1, {1'b1, 8'h33})}, 16);
        chk("R5 load, att_l", att_l, 8'h40);
        chk("R5 load, att_r", att_r, 8'h33);
        send({1'b0, mk(5'b0, 2'd0, {1'b1, 8'h11})}, 16);
        chk("R5 load via left, att_l", att_l, 8'h11);
        chk("R5 load via left, att_r", att_r, 8'h33);
    endtask

    task automatic t_miscount;
        send({1'b0, mk(5'b0, 2'd2, 9'h000)}, 15);
        chk("R3 short word ignored", {omode, wl, op_en, deemph, mute}, 9'b1010_10_1_0_1);
        send({1'b1, mk(5'b0, 2'd2, 9'h000)}, 17);
        chk("R3 long word ignored", {omode, wl, op_en, deemph, mute}, 9'b1010_10_1_0_1);
        send({1'b0, mk(5'b0, 2'd2, 9'h003)}, 16);
        chk("R3 recovery after miscount", {omode, wl, op_en, deemph, mute}, 9'h003);
    endtask

    task automatic t_common;
        send({1'b0, mk(5'b0, 2'd3, 9'b0_00_00_0_1_0_0)}, 16);
        chk("R6 common on, att_r", att_r, 8'h11);
        chk("R6 common on, att_l", att_l, 8'h11);
        chk("R9 fmt kept after sys", {omode, wl, op_en, deemph, mute}, 9'h003);
        send({1'b0, mk(5'b0, 2'd3, 9'b0)}, 16);
        chk("R6 common off, att_r", att_r, 8'h33);
    endtask

    initial begin
        idle(4);
        rst = 0;
        idle(2);
        t_reset;
        t_fmt;
        t_sys;
        t_stage;
        t_miscount;
        t_common;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule